// File: doc/BRIEF.md
# Root-Port Interrupt Aggregator

This block gathers the interrupts of one root port into a single level interrupt for the processor. There are two kinds of source. Message-signalled interrupts arrive as inbound 32-bit memory writes. A write whose address equals a software-programmed target address latches one bit of a 32-entry vector bitmap, and the write data selects the bit. Four legacy level lines are also sampled into sticky status bits. A summary bit stands for the whole vector bitmap. The summary bit and the four legacy bits share one status word and one mask word, and the output interrupt is raised for any of these bits that is set while its mask bit is clear.

Software programs the target address and the mask through a small word-addressed register port. It reads the status words and clears individual bits by writing ones. The usual service loop reads the vector bitmap and clears the bits it handles. It rereads the bitmap until it reads zero, then clears the summary bit. A vector that arrives during the loop therefore stays visible and is not lost.

The output is the Moore output of a two-state machine, `IRQ_IDLE` and `IRQ_ACTIVE`. The transition `IRQ_IDLE -> IRQ_ACTIVE` is taken when at least one unmasked status bit is set. The transition `IRQ_ACTIVE -> IRQ_IDLE` is taken when no unmasked status bit is set. In every other case the machine stays where it is.

Top module: `irqagg_top`

## Requirements
- R1: After reset, both status words and the vector bitmap read zero, the target address reads zero, the mask word reads 32'h008F_0000 (every source masked), and `irq_o` is 0.
- R2: An inbound write with `in_wr_valid` high, `in_wr_addr` equal to the target address and `in_wr_data` below 32 sets bit `in_wr_data` of the vector bitmap (register offset 2) at that clock edge. The bitmap is readable in the following cycle.
- R3: An inbound write whose address differs from the target address, or whose data is 32 or more, leaves the vector bitmap and the summary bit unchanged.
- R4: A register write to offset 2 clears each vector bitmap bit whose data bit is 1. Bits written with 0 are unchanged.
- R5: If an inbound write sets a vector bit in the same cycle that a register write clears that bit, the bit ends up set. The same rule applies to the summary bit and to the legacy bits.
- R6: The main status word (offset 0) holds the summary bit at bit 23. It is set at every edge where a vector bit is set, it is cleared by writing 1 to bit 23 at offset 0, and every other status bit reads 0 except bits 19:16.
- R7: Bits 19:16 of the main status word latch legacy inputs `intx_i[3:0]` at every edge where the input is high. Writing 1 clears a bit only once its input has gone low.
- R8: The mask word (offset 1) uses bit 23 for the summary source and bits 19:16 for the legacy sources. A 1 masks the source and a 0 enables it. The other bits of the mask word are not stored and read 0.
- R9: `irq_o` is 1 exactly one cycle after an edge that leaves some status bit set with its mask bit clear, and 0 one cycle after an edge that leaves no such bit.
- R10: The target address register (offset 3) stores and returns all 32 bits written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write word offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 2 | Register read word offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| in_wr_valid | input | 1 | Inbound memory write present |
| in_wr_addr | input | 32 | Inbound write address |
| in_wr_data | input | 32 | Inbound write data (vector number) |
| intx_i | input | 4 | Legacy level interrupt inputs |
| irq_o | output | 1 | Aggregated interrupt to the processor |

## Verification
The bench sends a vector set and a clear of the same bit in one cycle. A design where the clear wins would drop that vector, and the service loop would then miss it. It sends inbound writes with data 32 and writes to a wrong address. A design that masks the vector index to five bits, or that skips the address compare, would set a spurious bit. It clears a legacy bit while its line is still high and clears the summary bit while vector bits remain set. A wrong design would lose a held legacy level, or would not raise the summary again on the next vector. A reference model compares the output and the selected register every cycle, so an interrupt that comes a cycle early or late, or a stored mask bit that reads back when it should not, shows up as a mismatch.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Register word offsets on the register port
    typedef enum logic [1:0] {
        REG_MAIN_STAT = 2'd0,
        REG_MASK      = 2'd1,
        REG_VEC_STAT  = 2'd2,
        REG_TARGET    = 2'd3
    } reg_sel_e;

    // Bit positions decoded by the service software
    localparam int unsigned SUM_POS  = 23;
    localparam int unsigned INTX_LSB = 16;

    // Output machine
    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

endpackage

// File: rtl/irqagg_msi_capture.sv
module irqagg_msi_capture #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned VEC_COUNT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_addr,
    input  logic [DATA_W-1:0]    in_data,
    input  logic                 tgt_wr,
    input  logic [DATA_W-1:0]    tgt_wdata,
    input  logic                 clr_en,
    input  logic [VEC_COUNT-1:0] clr_bits,
    output logic [DATA_W-1:0]    target_q,
    output logic [VEC_COUNT-1:0] vec_q,
    output logic                 vec_hit
);
    localparam int unsigned VIDX_W = $clog2(VEC_COUNT);

    logic [VEC_COUNT-1:0] set_bits;

    // Address match and range check of the vector number
    assign vec_hit = in_valid && (in_addr == target_q) &&
                     (in_data < DATA_W'(VEC_COUNT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (tgt_wr) begin
            target_q <= tgt_wdata;
        end
    end

    // One status cell per vector; a set event wins over a clear
    for (genvar i = 0; i < VEC_COUNT; i++) begin : g_vec
        assign set_bits[i] = vec_hit && (in_data[VIDX_W-1:0] == VIDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vec_q[i] <= 1'b0;
            end else begin
                vec_q[i] <= (vec_q[i] & ~(clr_en & clr_bits[i])) | set_bits[i];
            end
        end
    end

endmodule

// File: rtl/irqagg_main_status.sv
module irqagg_main_status
    import irqagg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned INTX_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_hit,
    input  logic [INTX_N-1:0] intx_i,
    input  logic              clr_en,
    input  logic              clr_sum,
    input  logic [INTX_N-1:0] clr_intx,
    input  logic              mask_wr,
    input  logic              mask_sum_d,
    input  logic [INTX_N-1:0] mask_intx_d,
    output logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] mask_word,
    output logic              pending
);
    logic              sum_q;
    logic [INTX_N-1:0] intx_q;
    logic              msk_sum_q;
    logic [INTX_N-1:0] msk_intx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= 1'b0;
        end else begin
            sum_q <= (sum_q & ~(clr_en & clr_sum)) | vec_hit;
        end
    end

    for (genvar k = 0; k < INTX_N; k++) begin : g_intx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                intx_q[k] <= 1'b0;
            end else begin
                intx_q[k] <= (intx_q[k] & ~(clr_en & clr_intx[k])) | intx_i[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msk_sum_q  <= 1'b1;
            msk_intx_q <= '1;
        end else if (mask_wr) begin
            msk_sum_q  <= mask_sum_d;
            msk_intx_q <= mask_intx_d;
        end
    end

    always_comb begin
        status_word                        = '0;
        status_word[SUM_POS]               = sum_q;
        status_word[INTX_LSB +: INTX_N]    = intx_q;
        mask_word                          = '0;
        mask_word[SUM_POS]                 = msk_sum_q;
        mask_word[INTX_LSB +: INTX_N]      = msk_intx_q;
    end

    assign pending = (sum_q & ~msk_sum_q) | (|(intx_q & ~msk_intx_q));

endmodule

// File: rtl/irqagg_irq_fsm.sv
module irqagg_irq_fsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!pending) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_ACTIVE: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned VEC_COUNT = 32,
    parameter int unsigned INTX_N    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [1:0]        reg_rd_addr,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              in_wr_valid,
    input  logic [DATA_W-1:0] in_wr_addr,
    input  logic [DATA_W-1:0] in_wr_data,
    input  logic [INTX_N-1:0] intx_i,
    output logic              irq_o
);
    reg_sel_e wr_sel, rd_sel;

    logic                 wr_main, wr_mask, wr_vec, wr_tgt;
    logic [DATA_W-1:0]    target_q;
    logic [VEC_COUNT-1:0] vec_q;
    logic                 vec_hit;
    logic [DATA_W-1:0]    status_q;
    logic [DATA_W-1:0]    mask_q;
    logic                 pending;
    logic [DATA_W-1:0]    vec_word;

    assign wr_sel = reg_sel_e'(reg_wr_addr);
    assign rd_sel = reg_sel_e'(reg_rd_addr);

    always_comb begin
        wr_main = 1'b0;
        wr_mask = 1'b0;
        wr_vec  = 1'b0;
        wr_tgt  = 1'b0;
        unique case (wr_sel)
            REG_MAIN_STAT: wr_main = reg_wr_en;
            REG_MASK:      wr_mask = reg_wr_en;
            REG_VEC_STAT:  wr_vec  = reg_wr_en;
            REG_TARGET:    wr_tgt  = reg_wr_en;
            default:       ;
        endcase
    end

    irqagg_msi_capture #(
        .DATA_W    (DATA_W),
        .VEC_COUNT (VEC_COUNT)
    ) u_msi (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_wr_valid),
        .in_addr   (in_wr_addr),
        .in_data   (in_wr_data),
        .tgt_wr    (wr_tgt),
        .tgt_wdata (reg_wr_data),
        .clr_en    (wr_vec),
        .clr_bits  (reg_wr_data[VEC_COUNT-1:0]),
        .target_q  (target_q),
        .vec_q     (vec_q),
        .vec_hit   (vec_hit)
    );

    irqagg_main_status #(
        .DATA_W (DATA_W),
        .INTX_N (INTX_N)
    ) u_main (
        .clk         (clk),
        .rst_n       (rst_n),
        .vec_hit     (vec_hit),
        .intx_i      (intx_i),
        .clr_en      (wr_main),
        .clr_sum     (reg_wr_data[SUM_POS]),
        .clr_intx    (reg_wr_data[INTX_LSB +: INTX_N]),
        .mask_wr     (wr_mask),
        .mask_sum_d  (reg_wr_data[SUM_POS]),
        .mask_intx_d (reg_wr_data[INTX_LSB +: INTX_N]),
        .status_word (status_q),
        .mask_word   (mask_q),
        .pending     (pending)
    );

    irqagg_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq_o   (irq_o)
    );

    always_comb begin
        vec_word                  = '0;
        vec_word[VEC_COUNT-1:0]   = vec_q;
    end

    always_comb begin
        unique case (rd_sel)
            REG_MAIN_STAT: reg_rd_data = status_q;
            REG_MASK:      reg_rd_data = mask_q;
            REG_VEC_STAT:  reg_rd_data = vec_word;
            REG_TARGET:    reg_rd_data = target_q;
            default:       reg_rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned VEC_COUNT = 32,
    parameter int unsigned INTX_N    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_wr_valid,
    input logic [DATA_W-1:0]    in_wr_addr,
    input logic [DATA_W-1:0]    in_wr_data,
    input logic                 reg_wr_en,
    input logic [1:0]           reg_wr_addr,
    input logic [INTX_N-1:0]    intx_i,
    input logic                 irq_o,
    input logic [DATA_W-1:0]    target_q,
    input logic [VEC_COUNT-1:0] vec_q,
    input logic [DATA_W-1:0]    status_q,
    input logic [DATA_W-1:0]    mask_q
);
    localparam int unsigned VIDX_W = $clog2(VEC_COUNT);

    logic                 accept;
    logic [VEC_COUNT-1:0] expect_set_q;

    assign accept = in_wr_valid && (in_wr_addr == target_q) &&
                    (in_wr_data < DATA_W'(VEC_COUNT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expect_set_q <= '0;
        end else begin
            expect_set_q <= accept ? (VEC_COUNT'(1) << in_wr_data[VIDX_W-1:0]) : '0;
        end
    end

    // R2 and R5: an accepted vector is present after the edge, even under a clear
    p_vec_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_q & expect_set_q) == expect_set_q);

    // R6: the summary bit follows any accepted vector
    p_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expect_set_q != '0) |-> status_q[SUM_POS]);

    // R3: an out-of-range vector number leaves the bitmap alone
    p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wr_valid && (in_wr_data >= DATA_W'(VEC_COUNT)) &&
         !(reg_wr_en && reg_wr_addr == 2'd2)) |=> $stable(vec_q));

    // R7: a high legacy line is latched at the edge
    p_intx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_i != '0) |=> ((status_q[INTX_LSB +: INTX_N] & $past(intx_i)) == $past(intx_i)));

    // R9: the output follows the unmasked status one cycle later
    p_irq_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status_q & ~mask_q))));

    // R8: with nothing unmasked pending the output drops
    p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~mask_q) == '0) |=> !irq_o);

endmodule

bind irqagg_top irqagg_checker #(
    .DATA_W    (DATA_W),
    .VEC_COUNT (VEC_COUNT),
    .INTX_N    (INTX_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_wr_valid (in_wr_valid),
    .in_wr_addr  (in_wr_addr),
    .in_wr_data  (in_wr_data),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .intx_i      (intx_i),
    .irq_o       (irq_o),
    .target_q    (target_q),
    .vec_q       (vec_q),
    .status_q    (status_q),
    .mask_q      (mask_q)
);

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        in_wr_valid = 1'b0;
    logic [31:0] in_wr_addr = '0;
    logic [31:0] in_wr_data = '0;
    logic [3:0]  intx_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irqagg_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data),
        .in_wr_valid (in_wr_valid),
        .in_wr_addr  (in_wr_addr),
        .in_wr_data  (in_wr_data),
        .intx_i      (intx_i),
        .irq_o       (irq_o)
    );

    // Behavioural reference model
    logic [31:0] m_vec, m_tgt;
    logic        m_sum, m_msum, m_irq;
    logic [3:0]  m_intx, m_mintx;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_vec = 0; m_tgt = 0; m_sum = 0; m_intx = 0;
            m_msum = 1; m_mintx = 4'hF; m_irq = 0;
        end else begin
            logic [31:0] setv;
            logic        next_irq;
            next_irq = (m_sum && !m_msum) || ((m_intx & ~m_mintx) != 0);
            setv = 0;
            if (in_wr_valid && in_wr_addr == m_tgt && in_wr_data < 32)
                setv = 32'd1 << in_wr_data;
            if (reg_wr_en && reg_wr_addr == 2'd2) m_vec = m_vec & ~reg_wr_data;
            m_vec = m_vec | setv;
            if (reg_wr_en && reg_wr_addr == 2'd0) begin
                if (reg_wr_data[23]) m_sum = 0;
                m_intx = m_intx & ~reg_wr_data[19:16];
            end
            if (setv != 0) m_sum = 1;
            m_intx = m_intx | intx_i;
            if (reg_wr_en && reg_wr_addr == 2'd1) begin
                m_msum  = reg_wr_data[23];
                m_mintx = reg_wr_data[19:16];
            end
            if (reg_wr_en && reg_wr_addr == 2'd3) m_tgt = reg_wr_data;
            m_irq = next_irq;
        end
    end

    function automatic logic [31:0] model_rd(logic [1:0] a);
        logic [31:0] v;
        v = 0;
        case (a)
            2'd0: begin v[23] = m_sum;  v[19:16] = m_intx;  end
            2'd1: begin v[23] = m_msum; v[19:16] = m_mintx; end
            2'd2: v = m_vec;
            default: v = m_tgt;
        endcase
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            chk("R9 irq_o vs model", {31'd0, irq_o}, {31'd0, m_irq});
            case (reg_rd_addr)
                2'd0: tag = "R6 main status vs model";
                2'd1: tag = "R8 mask vs model";
                2'd2: tag = "R2 vector bitmap vs model";
                default: tag = "R10 target vs model";
            endcase
            chk(tag, reg_rd_data, model_rd(reg_rd_addr));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
        step();
        reg_wr_en = 0; reg_wr_data = 0;
    endtask

    task automatic inbound(logic [31:0] a, logic [31:0] d);
        in_wr_valid = 1; in_wr_addr = a; in_wr_data = d;
        step();
        in_wr_valid = 0;
    endtask

    task automatic read_chk(string req, logic [1:0] a, logic [31:0] exp);
        reg_rd_addr = a;
        #0.5;
        chk(req, reg_rd_data, exp);
    endtask

    localparam logic [31:0] TGT = 32'h1000_0040;

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        // R1 reset values, sampled while reset is held
        read_chk("R1 main status at reset", 2'd0, 32'h0);
        read_chk("R1 mask at reset", 2'd1, 32'h008F_0000);
        read_chk("R1 vector bitmap at reset", 2'd2, 32'h0);
        read_chk("R1 target at reset", 2'd3, 32'h0);
        chk("R1 irq at reset", {31'd0, irq_o}, 32'd0);
        rst_n = 1;
        step();

        // R10 target register
        reg_write(2'd3, TGT);
        read_chk("R10 target readback", 2'd3, TGT);

        // R2 vector capture and summary
        inbound(TGT, 32'd5);
        read_chk("R2 vector 5 set", 2'd2, 32'h0000_0020);
        read_chk("R6 summary set", 2'd0, 32'h0080_0000);
        chk("R8 masked summary keeps irq low", {31'd0, irq_o}, 32'd0);

        // R3 ignored inbound writes
        inbound(TGT, 32'd32);
        read_chk("R3 data 32 ignored", 2'd2, 32'h0000_0020);
        inbound(TGT + 32'd4, 32'd7);
        read_chk("R3 wrong address ignored", 2'd2, 32'h0000_0020);

        // R4 write-one-to-clear of the bitmap
        inbound(TGT, 32'd31);
        reg_write(2'd2, 32'h0000_0020);
        read_chk("R4 bit 5 cleared, bit 31 kept", 2'd2, 32'h8000_0000);

        // R5 set beats clear in the same cycle
        reg_wr_en = 1; reg_wr_addr = 2'd2; reg_wr_data = 32'h8000_0200;
        in_wr_valid = 1; in_wr_addr = TGT; in_wr_data = 32'd9;
        step();
        reg_wr_en = 0; in_wr_valid = 0;
        read_chk("R5 vector 9 survives clear", 2'd2, 32'h0000_0200);

        // R6 summary clear then re-set by a new vector
        reg_write(2'd0, 32'h0080_0000);
        read_chk("R6 summary cleared", 2'd0, 32'h0);
        inbound(TGT, 32'd3);
        read_chk("R6 summary set again", 2'd0, 32'h0080_0000);

        // R8 unmask summary; R9 irq one cycle after the mask edge
        reg_write(2'd1, 32'hFF7F_FFFF);
        read_chk("R8 mask keeps only defined bits", 2'd1, 32'h000F_0000);
        chk("R9 irq not yet high", {31'd0, irq_o}, 32'd0);
        step();
        chk("R9 irq high one cycle later", {31'd0, irq_o}, 32'd1);
        reg_write(2'd0, 32'h0080_0000);
        chk("R9 irq still high in clear cycle", {31'd0, irq_o}, 32'd1);
        step();
        chk("R9 irq drops after clear", {31'd0, irq_o}, 32'd0);

        // R7 legacy lines: held level survives a clear
        reg_write(2'd1, 32'h0080_0000);
        intx_i = 4'b0010;
        step();
        read_chk("R7 legacy 1 latched", 2'd0, 32'h0002_0000);
        reg_write(2'd0, 32'h0002_0000);
        read_chk("R7 held level survives clear", 2'd0, 32'h0002_0000);
        intx_i = 4'b0000;
        reg_write(2'd0, 32'h0002_0000);
        read_chk("R7 cleared after release", 2'd0, 32'h0);

        // Mixed random traffic checked by the model every cycle
        for (int n = 0; n < 600; n++) begin
            reg_rd_addr = 2'($urandom_range(0, 3));
            intx_i      = 4'($urandom) & 4'($urandom);
            in_wr_valid = ($urandom_range(0, 2) == 0);
            in_wr_addr  = ($urandom_range(0, 4) == 0) ? TGT ^ 32'h10 : TGT;
            in_wr_data  = 32'($urandom_range(0, 36));
            reg_wr_en   = ($urandom_range(0, 3) == 0);
            reg_wr_addr = 2'($urandom_range(0, 2));
            reg_wr_data = $urandom;
            step();
        end
        reg_wr_en = 0; in_wr_valid = 0; intx_i = 0;
        step();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule